// File: doc/BRIEF.md
# Mean-Level CFAR Acquisition Detector

This block decides, for a PN code search, whether the code-phase hypothesis under test holds the signal. It is fed one squared correlator magnitude per input beat. Each group of `PDI_LEN` accepted beats is added into one integrated statistic, which stands for one code-phase hypothesis. The statistics then move through a sliding window of `REF_CELLS + 1` cells. The cell in the middle of the window is the cell under test. The cells on either side of it serve as the noise reference.

The detection threshold is not fixed. It is the sum of the reference cells multiplied by a constant factor, `SCALE_NUM / 2^SCALE_SHIFT`, with a default of 109/256 (about 0.426). Because the threshold follows the local noise level, the false-alarm rate stays the same when the received level drifts or fades. The comparison is done by cross-multiplication, so no divider is needed.

Once the window is full, the block issues one decision for every new statistic. A decision is a valid strobe, a hit flag, and the code-phase index of the tested cell. A synchronous clear starts a new search.

Top module: `cfar_ml_detector`

## Requirements
- R1: Accepted input beats (those with `in_valid` high) are grouped without overlap into runs of `PDI_LEN` consecutive beats. Each run gives one integrated value equal to the sum of its beats. Cycles with `in_valid` low neither add to a run nor break it.
- R2: The window holds the latest `REF_CELLS + 1` integrated values. The cell under test is the one with `REF_CELLS/2` newer values and `REF_CELLS/2` older values around it.
- R3: The reference level X is the exact sum of the `REF_CELLS` cells other than the cell under test. Neither the run sum nor X wraps, even when every beat is at full scale (2^`SAMP_W` - 1).
- R4: `out_hit` is 1 exactly when Y·2^`SCALE_SHIFT` > X·`SCALE_NUM`, where Y is the cell under test. The comparison is strict, so equality gives no hit. Defaults: `SCALE_NUM` = 109, `SCALE_SHIFT` = 8.
- R5: After reset or clear, no decision is issued until `REF_CELLS + 1` integrated values have entered. From then on, exactly one decision (`out_valid` high for one cycle) is issued per new integrated value.
- R6: Integrated values are numbered from 0 after reset or clear, modulo 2^`IDX_W`. `out_idx` carries the number of the cell under test, so the first decision reports `REF_CELLS/2`.
- R7: `out_hit` is never 1 while `out_valid` is 0.
- R8: `clr` high on a clock edge empties the window and restarts both the beat grouping and the numbering. Any decision still in the pipeline is dropped, so `out_valid` is 0 in the cycle that follows.
- R9: Synchronous active-high reset drives `out_valid`, `out_hit` and `out_idx` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous search restart |
| in_valid | input | 1 | Input beat qualifier |
| in_sample | input | SAMP_W | Unsigned squared correlator magnitude |
| out_valid | output | 1 | One-cycle decision strobe |
| out_hit | output | 1 | Detection flag for the tested cell |
| out_idx | output | IDX_W | Code-phase index of the tested cell |

## Verification
The bench builds the block with its default parameters: 16-bit beats, three beats per run, eight reference cells and a factor of 109/256. This configuration is small enough that every decision of a long randomized stream, including idle gaps and occasional spikes, can be predicted arithmetically in the bench.

It also brings the edge cases within reach:
- the exact equality point of the threshold (reference cells of 32 against a test cell of 109 or 110);
- all-ones and all-zero windows;
- a window that is one value short of full;
- a clear that lands while a decision is still in the pipeline.

// File: rtl/cfar_pkg.sv
package cfar_pkg;

  // Bits needed to hold the sum of `count` values that are each `base` bits wide.
  function automatic int sum_width(input int base, input int count);
    if (count <= 1) return base;
    return base + $clog2(count);
  endfunction

  // Bits needed to hold the unsigned value v.
  function automatic int value_width(input int v);
    if (v <= 1) return 1;
    return $clog2(v + 1);
  endfunction

endpackage

// File: rtl/cfar_pdi_accum.sv
module cfar_pdi_accum #(
  parameter int SAMP_W  = 16,
  parameter int PDI_LEN = 3,
  parameter int SUM_W   = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [SAMP_W-1:0] in_sample,
  output logic              pdi_valid,
  output logic [SUM_W-1:0]  pdi_sum
);
  localparam int CNT_W = (PDI_LEN > 1) ? $clog2(PDI_LEN) : 1;
  localparam longint unsigned SUM_MAX = longint'(PDI_LEN) * ((longint'(1) << SAMP_W) - 1);

  logic [CNT_W-1:0] grp_cnt_q;
  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] beat_ext;
  logic             last_beat;

  assign beat_ext  = SUM_W'(in_sample);
  assign last_beat = (grp_cnt_q == CNT_W'(PDI_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      grp_cnt_q <= '0;
      acc_q     <= '0;
      pdi_valid <= 1'b0;
      pdi_sum   <= '0;
    end else begin
      pdi_valid <= 1'b0;
      if (in_valid) begin
        if (last_beat) begin
          pdi_sum   <= acc_q + beat_ext;
          pdi_valid <= 1'b1;
          acc_q     <= '0;
          grp_cnt_q <= '0;
        end else begin
          acc_q     <= acc_q + beat_ext;
          grp_cnt_q <= grp_cnt_q + CNT_W'(1);
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    pdi_valid |-> ({32'd0, pdi_sum} <= 64'(SUM_MAX))); // R3

  generate
    if (PDI_LEN > 1) begin : g_spacing
      AST_PDI_SPACING: assert property (@(posedge clk) disable iff (rst)
        pdi_valid |=> !pdi_valid); // R1
    end
  endgenerate

endmodule

// File: rtl/cfar_window.sv
module cfar_window #(
  parameter int SUM_W     = 18,
  parameter int REF_CELLS = 8,
  parameter int IDX_W     = 12,
  parameter int XSUM_W    = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              pdi_valid,
  input  logic [SUM_W-1:0]  pdi_sum,
  output logic              win_upd,
  output logic [SUM_W-1:0]  test_val,
  output logic [XSUM_W-1:0] ref_sum,
  output logic [IDX_W-1:0]  test_idx
);
  localparam int CELLS  = REF_CELLS + 1;
  localparam int HALF   = REF_CELLS / 2;
  localparam int FILL_W = $clog2(CELLS + 1);

  logic [SUM_W-1:0]  cell_q [CELLS];
  logic [XSUM_W-1:0] part   [CELLS+1];
  logic [FILL_W-1:0] fill_q;
  logic [IDX_W-1:0]  cnt_q;
  logic              upd_q;

  // Data cells carry no reset so that they can map to shift-register primitives.
  always_ff @(posedge clk) begin
    if (pdi_valid && !clr) begin
      cell_q[0] <= pdi_sum;
      for (int i = 1; i < CELLS; i++) cell_q[i] <= cell_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fill_q <= '0;
      cnt_q  <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (pdi_valid) begin
        cnt_q <= cnt_q + IDX_W'(1);
        if (fill_q != FILL_W'(CELLS)) fill_q <= fill_q + FILL_W'(1);
        upd_q <= (fill_q >= FILL_W'(CELLS - 1));
      end
    end
  end

  // Adder chain over the reference cells; the centre cell is skipped.
  assign part[0] = '0;
  generate
    for (genvar g = 0; g < CELLS; g++) begin : g_ref
      if (g == HALF) begin : g_skip
        assign part[g+1] = part[g];
      end else begin : g_add
        assign part[g+1] = part[g] + XSUM_W'(cell_q[g]);
      end
    end
  endgenerate

  assign ref_sum  = part[CELLS];
  assign test_val = cell_q[HALF];
  assign test_idx = cnt_q - IDX_W'(HALF + 1);
  assign win_upd  = upd_q;

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill_q <= FILL_W'(CELLS)); // R5

  AST_UPD_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    win_upd |-> (fill_q == FILL_W'(CELLS))); // R5

endmodule

// File: rtl/cfar_decide.sv
module cfar_decide #(
  parameter int SUM_W       = 18,
  parameter int XSUM_W      = 21,
  parameter int IDX_W       = 12,
  parameter int SCALE_NUM   = 109,
  parameter int SCALE_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              win_upd,
  input  logic [SUM_W-1:0]  test_val,
  input  logic [XSUM_W-1:0] ref_sum,
  input  logic [IDX_W-1:0]  test_idx,
  output logic              out_valid,
  output logic              out_hit,
  output logic [IDX_W-1:0]  out_idx
);
  localparam int NUM_W = cfar_pkg::value_width(SCALE_NUM);
  localparam int LW    = SUM_W + SCALE_SHIFT;
  localparam int RW    = XSUM_W + NUM_W;
  localparam int CMP_W = ((LW > RW) ? LW : RW) + 1;

  logic [CMP_W-1:0] lhs;
  logic [CMP_W-1:0] rhs;
  logic             above;

  // Cross-multiplied comparison: Y * 2^SHIFT against X * NUM, so no divider.
  assign lhs   = CMP_W'(test_val) << SCALE_SHIFT;
  assign rhs   = CMP_W'(ref_sum) * CMP_W'(SCALE_NUM);
  assign above = (lhs > rhs);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_idx   <= '0;
    end else begin
      out_valid <= win_upd;
      out_hit   <= win_upd && above;
      if (win_upd) out_idx <= test_idx;
    end
  end

  AST_HIT_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> out_valid); // R7

  AST_DECIDE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(win_upd)); // R5

endmodule

// File: rtl/cfar_ml_detector.sv
module cfar_ml_detector #(
  parameter int SAMP_W      = 16,
  parameter int PDI_LEN     = 3,
  parameter int REF_CELLS   = 8,
  parameter int IDX_W       = 12,
  parameter int SCALE_NUM   = 109,
  parameter int SCALE_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [SAMP_W-1:0] in_sample,
  output logic              out_valid,
  output logic              out_hit,
  output logic [IDX_W-1:0]  out_idx
);
  localparam int SUM_W  = cfar_pkg::sum_width(SAMP_W, PDI_LEN);
  localparam int XSUM_W = cfar_pkg::sum_width(SUM_W, REF_CELLS);

  logic              pdi_valid;
  logic [SUM_W-1:0]  pdi_sum;
  logic              win_upd;
  logic [SUM_W-1:0]  test_val;
  logic [XSUM_W-1:0] ref_sum;
  logic [IDX_W-1:0]  test_idx;

  cfar_pdi_accum #(
    .SAMP_W (SAMP_W),
    .PDI_LEN(PDI_LEN),
    .SUM_W  (SUM_W)
  ) u_accum (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .pdi_valid(pdi_valid),
    .pdi_sum  (pdi_sum)
  );

  cfar_window #(
    .SUM_W    (SUM_W),
    .REF_CELLS(REF_CELLS),
    .IDX_W    (IDX_W),
    .XSUM_W   (XSUM_W)
  ) u_window (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .pdi_valid(pdi_valid),
    .pdi_sum  (pdi_sum),
    .win_upd  (win_upd),
    .test_val (test_val),
    .ref_sum  (ref_sum),
    .test_idx (test_idx)
  );

  cfar_decide #(
    .SUM_W      (SUM_W),
    .XSUM_W     (XSUM_W),
    .IDX_W      (IDX_W),
    .SCALE_NUM  (SCALE_NUM),
    .SCALE_SHIFT(SCALE_SHIFT)
  ) u_decide (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .win_upd  (win_upd),
    .test_val (test_val),
    .ref_sum  (ref_sum),
    .test_idx (test_idx),
    .out_valid(out_valid),
    .out_hit  (out_hit),
    .out_idx  (out_idx)
  );

  AST_CLEAR_SILENCES: assert property (@(posedge clk) disable iff (rst)
    clr |=> !out_valid); // R8

endmodule

// File: tb/tb_cfar_ml_detector.sv
module tb_cfar_ml_detector;
  localparam int SAMP_W = 16;
  localparam int PDI_LEN = 3;
  localparam int REF_CELLS = 8;
  localparam int IDX_W = 12;
  localparam int HALF = REF_CELLS / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic [SAMP_W-1:0] in_sample = '0;
  logic out_valid;
  logic out_hit;
  logic [IDX_W-1:0] out_idx;

  always #4 clk = ~clk;

  cfar_ml_detector #(
    .SAMP_W(SAMP_W), .PDI_LEN(PDI_LEN), .REF_CELLS(REF_CELLS),
    .IDX_W(IDX_W), .SCALE_NUM(109), .SCALE_SHIFT(8)
  ) dut (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_hit(out_hit), .out_idx(out_idx)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  longint vals [0:1023];
  int     exp_idx [0:2047];
  bit     exp_hit [0:2047];
  int exp_n = 0;
  int got_n = 0;
  int stray_hits = 0;
  int unexpected = 0;
  int unsigned seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned next_rand();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  // Monitor: compares every decision against the precomputed expectations.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_hit && !out_valid) stray_hits++;
      if (out_valid) begin
        if (got_n < exp_n) begin
          check(int'(out_idx) == exp_idx[got_n], "R6 index", out_idx, exp_idx[got_n]);
          check(out_hit == exp_hit[got_n], "R1 R2 R3 R4 hit", out_hit, exp_hit[got_n]);
        end else begin
          unexpected++;
        end
        got_n++;
      end
    end
  end

  // Expected decisions from n integrated values fed after a clear.
  task automatic expect_seq(input int n);
    for (int j = HALF; j + HALF < n; j++) begin
      longint x = 0;
      for (int k = j - HALF; k <= j + HALF; k++) if (k != j) x += vals[k];
      exp_idx[exp_n] = j % (1 << IDX_W);
      exp_hit[exp_n] = (vals[j] * 256) > (x * 109);
      exp_n++;
    end
  endtask

  task automatic drive(input longint s);
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = SAMP_W'(s);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Feed n values as runs of three beats; gap_mode inserts idle cycles inside runs.
  task automatic feed(input int n, input bit gap_mode);
    for (int i = 0; i < n; i++) begin
      longint a = vals[i] / 3;
      drive(a);
      if (gap_mode && (i % 3 == 1)) idle(2);
      drive(a);
      if (gap_mode && (i % 5 == 2)) idle(1);
      drive(vals[i] - 2 * a);
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    in_valid = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic settle(input string req);
    idle(8);
    check(got_n == exp_n, req, got_n, exp_n);
  endtask

  task automatic run_seq(input int n, input bit gap_mode, input string req);
    do_clear();
    expect_seq(n);
    feed(n, gap_mode);
    settle(req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    check(out_hit == 1'b0, "R9 out_hit", out_hit, 0);
    check(out_idx == '0, "R9 out_idx", out_idx, 0);

    // Random stream with idle gaps and occasional spikes (R1 R2 R3 R4 R5 R6)
    for (int i = 0; i < 300; i++) begin
      longint s = 0;
      for (int k = 0; k < 3; k++) begin
        int unsigned r = next_rand();
        if (i % 7 == 3) s += 40000 + (r % 25535);
        else s += r % 16384;
      end
      vals[i] = s;
    end
    run_seq(300, 1'b1, "R5 decision count random");

    // R4: threshold equality point (8*32*109 == 109*256)
    for (int i = 0; i < 9; i++) vals[i] = 32;
    vals[HALF] = 109;
    run_seq(9, 1'b0, "R4 R5 equality count");
    vals[HALF] = 110;
    run_seq(9, 1'b0, "R4 R5 above count");

    // R3: full-scale and all-zero windows
    for (int i = 0; i < 12; i++) vals[i] = 196605;
    run_seq(12, 1'b0, "R3 full scale count");
    for (int i = 0; i < 9; i++) vals[i] = 0;
    vals[HALF] = 196605;
    run_seq(9, 1'b0, "R3 lone peak count");
    vals[HALF] = 0;
    run_seq(9, 1'b0, "R4 all zero count");

    // R2: spike at a reference position must not be tested there
    for (int i = 0; i < 9; i++) vals[i] = 100;
    vals[0] = 150000;
    run_seq(9, 1'b0, "R2 edge spike count");

    // R5: one value short of a full window gives nothing
    for (int i = 0; i < 8; i++) vals[i] = 5000;
    run_seq(8, 1'b0, "R5 short window count");

    // R8: clear while a decision is in flight drops it
    do_clear();
    for (int i = 0; i < 9; i++) vals[i] = 200;
    feed(9, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(out_valid == 1'b0, "R8 valid after clear", out_valid, 0);
    settle("R8 in-flight dropped");

    // R8: numbering and grouping restart after clear
    for (int i = 0; i < 10; i++) vals[i] = 300 + 50 * i;
    run_seq(10, 1'b1, "R8 restart count");

    check(stray_hits == 0, "R7 hit without valid", stray_hits, 0);
    check(unexpected == 0, "R5 unexpected decisions", unexpected, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule